// File: doc/BRIEF.md
# Simulation Run Terminator

This peripheral sits on a simple register bus and gives software running in a simulated system a way to end the run. Software writes one command word at offset zero of a 4 KiB window. The low half of that word selects an action and the high half carries an exit code. The block turns a pass or fail command into a one-cycle shutdown request and keeps the cause and the exit code in registers. A reset command becomes a one-cycle system reset request. The environment around the block watches these outputs and acts on them. The block itself does no shutdown and no reset sequencing.

Every read returns zero and changes nothing. An access of the wrong size or alignment gets an error response and has no other effect. Some writes are legal on the bus but mean nothing to the block: a write to any offset other than zero, or a command word whose status is not recognised. These writes set a sticky guest-error flag. The block also records the byte offset and the data of the most recent such write.

Each access is presented for one cycle with `busValid` high. The response appears on the next cycle. All outputs come from registers.

Top module: `finisher_top`

## Requirements
- R1: An access is legal only when `busStrb` is 4'b0011, 4'b1100 or 4'b1111 and `busAddr[1:0]` is zero. An illegal access, read or write, gives `rspErr`=1 in the cycle after it and changes no other output except `rspValid`.
- R2: Every access gives `rspValid`=1 for exactly the following cycle. `rspRdata` is always zero, and a legal read changes no other output.
- R3: A legal 32-bit write (`busStrb`=4'b1111) of status 16'h5555 to word 0 gives `shutdownPulse`=1 for one cycle, starting the cycle after the write. In that same cycle `shutdownCause` is 0 (pass) and `exitCode` equals write data bits 31:16.
- R4: Status 16'h3333 at offset zero does the same as R3, except that `shutdownCause` is 1 (fail).
- R5: Status 16'h7777 at offset zero gives `resetPulse`=1 for one cycle. `exitCode` and `shutdownCause` keep their previous values.
- R6: A write at offset zero whose status is not one of the three codes sets `guestErr`. It causes no pulse.
- R7: A legal write whose byte offset is not zero sets `guestErr` and causes no pulse. The byte offset is (address & 12'hFFC), plus 2 when the strobe is 4'b1100. `errOffset` takes this offset and `errData` takes the full write data.
- R8: A 16-bit write on lanes 4'b0011 at word 0 takes its status from bits 15:0. Its exit code is taken as zero, whatever the upper data bits are.
- R9: `guestErr` stays set until reset. `errOffset` and `errData` always show the most recent guest-error write.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Access presented this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address inside the window |
| busWdata | input | 32 | Write data |
| busStrb | input | 4 | Byte lane enables |
| rspValid | output | 1 | Response for the previous cycle's access |
| rspErr | output | 1 | Access was rejected for size or alignment |
| rspRdata | output | 32 | Read data, always zero |
| shutdownPulse | output | 1 | One-cycle shutdown request |
| shutdownCause | output | 1 | 0 = pass, 1 = fail, held until the next shutdown |
| exitCode | output | 16 | Exit code of the latest shutdown |
| resetPulse | output | 1 | One-cycle system reset request |
| guestErr | output | 1 | Sticky flag for meaningless writes |
| errOffset | output | 12 | Byte offset of the latest guest-error write |
| errData | output | 32 | Data of the latest guest-error write |

## Verification
The assertions check several rules on every cycle:
- shutdown and reset requests never fire together;
- a request never appears with a rejected access;
- any pulse or error comes with a response;
- a reset request leaves the cause and the exit code unchanged;
- the guest-error flag never clears outside reset.

Some behaviour only the bench's scenarios can show. That includes the exact decoding of the three status values and the zero exit code of half-word commands. It also includes the offset arithmetic for upper-lane writes and the capture of error data. The bench compares all of these against its own model on every clock.

// File: rtl/finisher_pkg.sv
package finisher_pkg;

  localparam logic [15:0] STAT_FAIL  = 16'h3333;
  localparam logic [15:0] STAT_PASS  = 16'h5555;
  localparam logic [15:0] STAT_RESET = 16'h7777;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic respond;    // an access was presented
    logic sizeErr;    // illegal size or alignment
    logic shutdown;   // request a shutdown
    logic causeFail;  // cause for the shutdown
    logic sysReset;   // request a system reset
    logic logErr;     // record a guest error
  } finStrobe_t;

endpackage

// File: rtl/finisher_ctrl.sv
module finisher_ctrl
  import finisher_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W/8-1:0] busStrb,
  output finStrobe_t          ctrlStrobe,
  output logic [ADDR_W-1:0]   accOffset,
  output logic [DATA_W/2-1:0] cmdCode
);
  localparam int STRB_W   = DATA_W / 8;
  localparam int HALF_W   = DATA_W / 2;
  localparam int HALF_S   = STRB_W / 2;
  localparam int LANE_LSB = $clog2(STRB_W);

  localparam logic [STRB_W-1:0] LO_MASK = {{HALF_S{1'b0}}, {HALF_S{1'b1}}};
  localparam logic [STRB_W-1:0] HI_MASK = ~LO_MASK;
  localparam logic [STRB_W-1:0] ALL_MASK = '1;

  logic isLo, isHi, isFull, aligned, sizeOk, wordZero, cmdHit;
  logic [HALF_W-1:0] statusField;

  assign isLo     = (busStrb == LO_MASK);
  assign isHi     = (busStrb == HI_MASK);
  assign isFull   = (busStrb == ALL_MASK);
  assign aligned  = (busAddr[LANE_LSB-1:0] == '0);
  assign sizeOk   = (isLo || isHi || isFull) && aligned;
  assign wordZero = (busAddr[ADDR_W-1:LANE_LSB] == '0);
  assign cmdHit   = wordZero && !isHi;

  assign statusField = busWdata[HALF_W-1:0];
  assign cmdCode     = isFull ? busWdata[DATA_W-1:HALF_W] : '0;

  always_comb begin
    accOffset = {busAddr[ADDR_W-1:LANE_LSB], {LANE_LSB{1'b0}}};
    if (isHi) accOffset = accOffset + ADDR_W'(HALF_W / 8);
  end

  always_comb begin
    ctrlStrobe = '0;
    ctrlStrobe.respond = busValid;
    if (busValid) begin
      if (!sizeOk) begin
        ctrlStrobe.sizeErr = 1'b1;
      end else if (busWrite) begin
        if (cmdHit) begin
          if (statusField == STAT_FAIL) begin
            ctrlStrobe.shutdown  = 1'b1;
            ctrlStrobe.causeFail = 1'b1;
          end else if (statusField == STAT_PASS) begin
            ctrlStrobe.shutdown  = 1'b1;
          end else if (statusField == STAT_RESET) begin
            ctrlStrobe.sysReset  = 1'b1;
          end else begin
            ctrlStrobe.logErr    = 1'b1;
          end
        end else begin
          ctrlStrobe.logErr = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/finisher_dp.sv
module finisher_dp
  import finisher_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  finStrobe_t          ctrlStrobe,
  input  logic [ADDR_W-1:0]   accOffset,
  input  logic [DATA_W/2-1:0] cmdCode,
  input  logic [DATA_W-1:0]   busWdata,
  output logic                rspValid,
  output logic                rspErr,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                shutdownPulse,
  output logic                shutdownCause,
  output logic [DATA_W/2-1:0] exitCode,
  output logic                resetPulse,
  output logic                guestErr,
  output logic [ADDR_W-1:0]   errOffset,
  output logic [DATA_W-1:0]   errData
);

  assign rspRdata = '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid      <= 1'b0;
      rspErr        <= 1'b0;
      shutdownPulse <= 1'b0;
      resetPulse    <= 1'b0;
    end else begin
      rspValid      <= ctrlStrobe.respond;
      rspErr        <= ctrlStrobe.sizeErr;
      shutdownPulse <= ctrlStrobe.shutdown;
      resetPulse    <= ctrlStrobe.sysReset;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutdownCause <= 1'b0;
      exitCode      <= '0;
    end else if (ctrlStrobe.shutdown) begin
      shutdownCause <= ctrlStrobe.causeFail;
      exitCode      <= cmdCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      guestErr  <= 1'b0;
      errOffset <= '0;
      errData   <= '0;
    end else if (ctrlStrobe.logErr) begin
      guestErr  <= 1'b1;
      errOffset <= accOffset;
      errData   <= busWdata;
    end
  end

endmodule

// File: rtl/finisher_top.sv
module finisher_top
  import finisher_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W/8-1:0] busStrb,
  output logic                rspValid,
  output logic                rspErr,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                shutdownPulse,
  output logic                shutdownCause,
  output logic [DATA_W/2-1:0] exitCode,
  output logic                resetPulse,
  output logic                guestErr,
  output logic [ADDR_W-1:0]   errOffset,
  output logic [DATA_W-1:0]   errData
);
  finStrobe_t          ctrlStrobe;
  logic [ADDR_W-1:0]   accOffset;
  logic [DATA_W/2-1:0] cmdCode;

  finisher_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busStrb   (busStrb),
    .ctrlStrobe(ctrlStrobe),
    .accOffset (accOffset),
    .cmdCode   (cmdCode)
  );

  finisher_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlStrobe   (ctrlStrobe),
    .accOffset    (accOffset),
    .cmdCode      (cmdCode),
    .busWdata     (busWdata),
    .rspValid     (rspValid),
    .rspErr       (rspErr),
    .rspRdata     (rspRdata),
    .shutdownPulse(shutdownPulse),
    .shutdownCause(shutdownCause),
    .exitCode     (exitCode),
    .resetPulse   (resetPulse),
    .guestErr     (guestErr),
    .errOffset    (errOffset),
    .errData      (errData)
  );

endmodule

// File: rtl/finisher_chk.sv
module finisher_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rspValid,
  input logic        rspErr,
  input logic        shutdownPulse,
  input logic        shutdownCause,
  input logic [15:0] exitCode,
  input logic        resetPulse,
  input logic        guestErr
);

  // R3, R5: the two request kinds are exclusive
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(shutdownPulse && resetPulse));

  // R1: a rejected access triggers nothing
  a_r1_reject_quiet: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> !shutdownPulse && !resetPulse);

  // R2: pulses and errors arrive as part of a response
  a_r2_with_response: assert property (@(posedge clk) disable iff (!rstN)
    (shutdownPulse || resetPulse || rspErr) |-> rspValid);

  // R5: a reset request keeps the shutdown cause and code
  a_r5_code_kept: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |-> $stable(exitCode) && $stable(shutdownCause));

  // R9: the guest-error flag never falls outside reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(guestErr) |-> guestErr);

endmodule

bind finisher_top finisher_chk u_chk (.*);

// File: tb/finisher_top_tb.sv
module finisher_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busStrb = '0;
  logic        rspValid, rspErr, shutdownPulse, shutdownCause, resetPulse, guestErr;
  logic [31:0] rspRdata, errData;
  logic [15:0] exitCode;
  logic [11:0] errOffset;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  finisher_top u_dut (.*);

  // behavioural reference
  logic        mRspV, mRspErr, mShut, mCause, mRst, mGErr;
  logic [15:0] mCode;
  logic [11:0] mOff;
  logic [31:0] mData;
  logic        legal;
  int          off;
  logic [15:0] st, cd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRspV = 0; mRspErr = 0; mShut = 0; mCause = 0; mRst = 0; mGErr = 0;
      mCode = 0; mOff = 0; mData = 0;
    end else begin
      mShut = 0; mRst = 0; mRspErr = 0;
      mRspV = busValid;
      if (busValid) begin
        legal = (busStrb == 4'h3 || busStrb == 4'hC || busStrb == 4'hF) && busAddr[1:0] == 2'b00;
        if (!legal) mRspErr = 1;
        else if (busWrite) begin
          off = int'(busAddr & 12'hFFC) + ((busStrb == 4'hC) ? 2 : 0);
          if (off == 0) begin
            st = busWdata[15:0];
            cd = (busStrb == 4'hF) ? busWdata[31:16] : 16'h0;
            if (st == 16'h3333) begin mShut = 1; mCause = 1; mCode = cd; end
            else if (st == 16'h5555) begin mShut = 1; mCause = 0; mCode = cd; end
            else if (st == 16'h7777) mRst = 1;
            else begin mGErr = 1; mOff = 12'(off); mData = busWdata; end
          end else begin
            mGErr = 1; mOff = 12'(off); mData = busWdata;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      chk("R2 rspValid", 32'(rspValid), 32'(mRspV));
      chk("R2 rspRdata", rspRdata, 32'h0);
      chk("R1 rspErr", 32'(rspErr), 32'(mRspErr));
      chk("R3 shutdownPulse", 32'(shutdownPulse), 32'(mShut));
      chk("R4 shutdownCause", 32'(shutdownCause), 32'(mCause));
      chk("R8 exitCode", 32'(exitCode), 32'(mCode));
      chk("R5 resetPulse", 32'(resetPulse), 32'(mRst));
      chk("R9 guestErr", 32'(guestErr), 32'(mGErr));
      chk("R7 errOffset", 32'(errOffset), 32'(mOff));
      chk("R7 errData", errData, mData);
    end
    if (cyc > 5000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    busValid = 1; busWrite = wr; busAddr = a; busWdata = d; busStrb = s;
    @(negedge clk);
    busValid = 0; busWrite = 0; busAddr = '0; busWdata = '0; busStrb = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(2);
    rstN = 1;
    @(negedge clk);
    // R10: reset state at ports
    chk("R10 reset outputs", {rspValid, rspErr, shutdownPulse, shutdownCause, resetPulse, guestErr},  6'b0);
    chk("R10 reset exitCode", 32'(exitCode), 0);
    chk("R10 reset errData", errData, 0);

    access(1, 12'h000, 32'hBEEF_5555, 4'hF);   // R3 pass
    idle(1);
    access(1, 12'h000, 32'h1234_3333, 4'hF);   // R4 fail
    access(1, 12'h000, 32'hAAAA_7777, 4'hF);   // R5 reset, code kept
    idle(1);
    access(1, 12'h000, 32'hFFFF_5555, 4'h3);   // R8 half-word pass, code 0
    access(0, 12'h000, 32'h0, 4'hF);           // R2 read
    access(0, 12'h010, 32'h0, 4'h3);           // R2 read elsewhere
    access(1, 12'h000, 32'h0000_3333, 4'h1);   // R1 byte write rejected
    access(1, 12'h002, 32'h0000_5555, 4'hF);   // R1 misaligned rejected
    access(0, 12'h000, 32'h0, 4'h6);           // R1 illegal read
    idle(1);
    chk("R1 no guest error from rejected access", 32'(guestErr), 0);
    access(1, 12'h000, 32'h9999_1111, 4'hF);   // R6 unknown status
    @(negedge clk);
    chk("R6 unknown status flagged", 32'(guestErr), 1);
    chk("R6 unknown status no pulse", 32'(shutdownPulse | resetPulse), 0);
    access(1, 12'h000, 32'h5555_0000, 4'hC);   // R7 upper lanes -> offset 2
    access(1, 12'h804, 32'hCAFE_5555, 4'hF);   // R7 other word
    idle(1);
    chk("R7 latest error offset", 32'(errOffset), 32'h804);
    access(1, 12'h000, 32'h0042_5555, 4'hF);   // R9 flag stays
    access(1, 12'h000, 32'h0007_3333, 4'hF);   // back-to-back
    access(1, 12'h000, 32'h0000_7777, 4'h3);
    idle(2);
    // R9: reset clears the sticky flag
    rstN = 0;
    idle(1);
    rstN = 1;
    @(negedge clk);
    chk("R9 flag cleared by reset", 32'(guestErr), 0);
    access(1, 12'hFFC, 32'h1, 4'hF);
    idle(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule